// File: doc/BRIEF.md
# Enable-Gated Single-Shot Timing Sequencer

This block turns an active-low enable and an external train of input pulses into a fixed sequence of timed single-shot outputs. An enable latch drops when enable is asserted. That falling edge opens a long timing window. While the window is open, a divide-by-two toggle stage is released and advances on falling edges of the input pulse train. Each rising edge of the toggle output fires a shorter single-shot pulse. When the window closes, the toggle stage is forced back to zero and held there.

All timing is measured in milliseconds, as a count of a one-cycle `ms_tick` strobe. The long and short durations are set by parameters (defaults 146 and 50). Both `enable_n` and `pulse_in` are asynchronous to `clk` and pass through two-flop synchronizers. The active-low `rst_n` is asynchronous. It returns every output and every counter to the idle state.

Top module: `shot_sequencer`

## Requirements
- R1: While `rst_n` is low and right after it is released, the outputs are `latch_q`=1, `window`=0, `tog_q`=0, `tog_qn`=1 and `short_pulse`=0.
- R2: A low level on `enable_n` passes through two synchronizing flops. `latch_q` goes from 1 to 0 on the third rising clock edge after `enable_n` falls.
- R3: Once `latch_q` is 0, it stays 0 until `rst_n` is asserted, whatever `enable_n` does afterwards.
- R4: `window` rises on the same edge on which `latch_q` falls. It stays high until the LONG_MS-th `ms_tick` seen after the edge that opened it, and falls on the edge that samples that tick.
- R5: While `window` is high, `tog_q` inverts once for each falling edge of the synchronized `pulse_in`. The edge is detected from the second and third flop of the `pulse_in` chain. Rising edges of `pulse_in` have no effect.
- R6: While `window` is low, `tog_q` is forced to 0 on the next edge. Falling edges of `pulse_in` outside the window leave it at 0.
- R7: `tog_qn` is always the complement of `tog_q`.
- R8: `short_pulse` rises on the edge after `tog_q` rises. It stays high until the SHORT_MS-th `ms_tick` seen after that edge.
- R9: A rise of `tog_q` while `short_pulse` is high is ignored. It neither extends nor restarts the pulse.
- R10: Asserting `rst_n` in the middle of a sequence returns all outputs to the R1 values at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle strobe, once per millisecond |
| enable_n | input | 1 | Active-low enable, asynchronous |
| pulse_in | input | 1 | External pulse train, asynchronous |
| latch_q | output | 1 | Enable latch state, 1 when idle |
| window | output | 1 | Long single-shot window |
| tog_q | output | 1 | Divide-by-two stage output |
| tog_qn | output | 1 | Complement of tog_q |
| short_pulse | output | 1 | Short single-shot output |

## Verification
Two events can land on the same clock edge. The first is the closing tick of the long window together with a synchronized falling edge of `pulse_in`: the toggle may still flip on that edge and must then be cleared on the next. The second is a toggle rise together with a short pulse that is still running or just expiring: the rise must be ignored.

The bench provokes both with seeded random pulse periods from 3 to 60 ms, some shorter than the short pulse. It adds a directed run with the first pulse 10 ms after enable and a 50 ms period. A cycle-by-cycle model built from the requirements judges every output on each falling clock edge.

// File: rtl/shot_sequencer.sv
module shot_sequencer #(
  parameter int LONG_MS  = 146,
  parameter int SHORT_MS = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic enable_n,
  input  logic pulse_in,
  output logic latch_q,
  output logic window,
  output logic tog_q,
  output logic tog_qn,
  output logic short_pulse
);
  localparam int LW = $clog2(LONG_MS + 1);
  localparam int SW = $clog2(SHORT_MS + 1);
  localparam logic [LW-1:0] LONG_LAST  = LW'(LONG_MS - 1);
  localparam logic [SW-1:0] SHORT_LAST = SW'(SHORT_MS - 1);

  logic [1:0]    en_sync, pi_sync;
  logic          pi_last, tog_last;
  logic [LW-1:0] lcnt;
  logic [SW-1:0] scnt;

  wire pi_fall   = pi_last & ~pi_sync[1];
  wire latch_clr = latch_q & ~en_sync[1];
  wire tog_rise  = tog_q & ~tog_last;

  assign tog_qn = ~tog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_sync <= 2'b11;
      pi_sync <= 2'b00;
      pi_last <= 1'b0;
    end else begin
      en_sync <= {en_sync[0], enable_n};
      pi_sync <= {pi_sync[0], pulse_in};
      pi_last <= pi_sync[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= 1'b1;
    else if (latch_clr) latch_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      window <= 1'b0;
      lcnt   <= '0;
    end else if (latch_clr) begin
      window <= 1'b1;
      lcnt   <= '0;
    end else if (window && ms_tick) begin
      if (lcnt == LONG_LAST) window <= 1'b0;
      else lcnt <= lcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q    <= 1'b0;
      tog_last <= 1'b0;
    end else begin
      tog_last <= tog_q;
      if (!window) tog_q <= 1'b0;
      else if (pi_fall) tog_q <= ~tog_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      short_pulse <= 1'b0;
      scnt        <= '0;
    end else if (!short_pulse) begin
      if (tog_rise) begin
        short_pulse <= 1'b1;
        scnt        <= '0;
      end
    end else if (ms_tick) begin
      if (scnt == SHORT_LAST) short_pulse <= 1'b0;
      else scnt <= scnt + 1'b1;
    end
  end
endmodule

// File: rtl/shot_sequencer_chk.sv
module shot_sequencer_chk (
  input logic clk,
  input logic rst_n,
  input logic latch_q,
  input logic window,
  input logic tog_q,
  input logic tog_qn,
  input logic short_pulse
);
  assert_latch_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_q |=> !latch_q);

  assert_window_opens_on_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(window) |-> $fell(latch_q));

  assert_toggle_held_outside_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !window |=> !tog_q);

  assert_complement_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tog_qn == !tog_q);

  assert_short_follows_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(short_pulse) |-> ($past(tog_q) && !$past(tog_q, 2)));
endmodule

bind shot_sequencer shot_sequencer_chk u_chk (.*);

// File: tb/test_shot_sequencer.sv
module test_shot_sequencer;
  localparam int TICK = 4;
  localparam int LONG_MS = 146;
  localparam int SHORT_MS = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_tick = 1'b0;
  logic enable_n = 1'b1;
  logic pulse_in = 1'b0;
  logic latch_q, window, tog_q, tog_qn, short_pulse;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  int tick_div = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  shot_sequencer #(.LONG_MS(LONG_MS), .SHORT_MS(SHORT_MS)) i_shot_sequencer (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .enable_n(enable_n),
    .pulse_in(pulse_in), .latch_q(latch_q), .window(window), .tog_q(tog_q),
    .tog_qn(tog_qn), .short_pulse(short_pulse)
  );

  // reference model, written from the requirements
  logic m_e1, m_e2, m_p1, m_p2, m_pd, m_latch, m_win, m_tog, m_td, m_short;
  int m_lc, m_sc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_e1 <= 1; m_e2 <= 1; m_p1 <= 0; m_p2 <= 0; m_pd <= 0;
      m_latch <= 1; m_win <= 0; m_lc <= 0; m_tog <= 0; m_td <= 0;
      m_short <= 0; m_sc <= 0;
    end else begin
      m_e1 <= enable_n; m_e2 <= m_e1;
      m_p1 <= pulse_in; m_p2 <= m_p1; m_pd <= m_p2;
      if (m_latch && !m_e2) m_latch <= 0;
      if (m_latch && !m_e2) begin m_win <= 1; m_lc <= 0; end
      else if (m_win && ms_tick) begin
        if (m_lc == LONG_MS - 1) m_win <= 0; else m_lc <= m_lc + 1;
      end
      m_td <= m_tog;
      if (!m_win) m_tog <= 0;
      else if (m_pd && !m_p2) m_tog <= !m_tog;
      if (!m_short) begin
        if (m_tog && !m_td) begin m_short <= 1; m_sc <= 0; end
      end else if (ms_tick) begin
        if (m_sc == SHORT_MS - 1) m_short <= 0; else m_sc <= m_sc + 1;
      end
    end
  end

  function automatic bit same(logic a, logic e);
    return a === e;
  endfunction

  task automatic check(logic a, logic e, string tag);
    n_run++;
    if (!same(a, e)) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at cycle %0d", tag, a, e, cyc);
    end
  endtask

  task automatic check_idle(string tag);
    check(latch_q, 1'b1, {tag, " latch_q"});
    check(window, 1'b0, {tag, " window"});
    check(tog_q, 1'b0, {tag, " tog_q"});
    check(tog_qn, 1'b1, {tag, " tog_qn"});
    check(short_pulse, 1'b0, {tag, " short_pulse"});
  endtask

  always @(negedge clk) begin
    cyc++;
    tick_div = (tick_div + 1) % TICK;
    ms_tick <= (tick_div == 0);
    if (rst_n) begin
      check(latch_q, m_latch, "R2 R3 latch_q");
      check(window, m_win, "R4 window");
      check(tog_q, m_tog, "R5 R6 tog_q");
      check(tog_qn, !m_tog, "R7 tog_qn");
      check(short_pulse, m_short, "R8 R9 short_pulse");
    end
    if (cyc > 200000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic wait_ms(int ms);
    repeat (ms * TICK) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; enable_n = 1; pulse_in = 0;
    #1 check_idle("R1 in reset");
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_idle("R1 after reset");
  endtask

  task automatic train(int first_ms, int period_ms, int count);
    wait_ms(first_ms);
    for (int i = 0; i < count; i++) begin
      pulse_in = 1;
      repeat ((period_ms * TICK) / 2) @(negedge clk);
      pulse_in = 0;
      repeat (period_ms * TICK - (period_ms * TICK) / 2) @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    // directed: first pulse 10 ms after enable, 50 ms period
    do_reset();
    train(2, 7, 4);               // R6: edges before enable ignored
    check(tog_q, 1'b0, "R6 pre-enable tog_q");
    enable_n = 0;
    repeat (2) @(negedge clk);
    check(latch_q, 1'b1, "R2 latch still high after two edges");
    @(negedge clk);
    check(latch_q, 1'b0, "R2 latch low on third edge");
    check(window, 1'b1, "R4 window open with latch fall");
    train(10, 50, 5);
    enable_n = 1;                 // R3: release has no effect
    wait_ms(SHORT_MS + 20);
    check(latch_q, 1'b0, "R3 latch sticky");
    check(window, 1'b0, "R4 window closed");
    check(tog_q, 1'b0, "R6 toggle cleared after window");

    // R5 R9: random periods, some shorter than the short pulse
    for (int s = 0; s < 7; s++) begin
      int pre, per, cnt;
      do_reset();
      pre = 1 + ($urandom % 20);
      per = 3 + ($urandom % 58);
      cnt = (LONG_MS + 40) / per + 1;
      wait_ms($urandom % 5);
      repeat ($urandom % TICK) @(negedge clk);
      enable_n = 0;
      if (s == 3) begin
        train(pre, per, cnt / 2);
        @(negedge clk);
        rst_n = 0;               // R10: asynchronous reset mid-window
        #1 check_idle("R10 mid-sequence reset");
        repeat (2) @(negedge clk);
        rst_n = 1;
        enable_n = 1;
        pulse_in = 0;
        @(negedge clk);
        check_idle("R10 after release");
      end else begin
        train(pre, per, cnt);
        pulse_in = 0;
        wait_ms(SHORT_MS + 5);
        check(window, 1'b0, "R4 window closed random");
      end
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule